// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is one output cell of a programmable sum-of-products logic device. The AND-OR array in front of it supplies two sum terms and three product terms: a clock, an asynchronous clear and an output enable. Every cell in the array also shares a direct clock pin (`clk`) and a synchronous preset term. A static configuration word sets four things. The storage bit acts as a D-type or a T-type flip-flop. It is clocked by the pin or by its own product-term clock. The two sum terms are either merged or split between the register and the combinational path. The pin shows either the registered value or the combinational term. The stored bit always returns to the array on `fb_o`, so the register can be buried while the pin does other work.

The storage bit is a two-state machine with states `BIT_CLR` (stored 0) and `BIT_SET` (stored 1). At each `clk` edge an event is chosen, and that event names the transition:
- `EV_PRELOAD` moves to the state given by `preload_val`.
- `EV_PRESET` moves to `BIT_SET`.
- `EV_TOGGLE` moves to the opposite state.
- `EV_LOAD_D` moves to the state given by the register term.
- `EV_HOLD` stays in the current state.

The asynchronous path forces `BIT_CLR` at once. It is taken on the product-term clear or on power-up reset.

The product-term clock is sampled on `clk`. An active edge is a `clk` edge at which `pt_clk` is 1 after having been 0 at the previous edge. When the pin clock is selected, every `clk` edge is active. The configuration word is captured only while `rst_n` is low.

Top module: `pldmc_cell`

## Requirements
- R1: While `rst_n` is low, `fb_o` is 0 and `cfg_word` is captured. When `rst_n` is released, the cell starts in `BIT_CLR`.
- R2: With `cfg_word[0]`=0 (D mode), the stored bit takes the register term at each active edge.
- R3: With `cfg_word[0]`=1 (T mode), the stored bit inverts at an active edge when the register term is 1, and holds when it is 0.
- R4: With `cfg_word[1]`=1, only `clk` edges at which `pt_clk` is 1 and was 0 at the previous edge are active. Holding `pt_clk` high gives one update. With `cfg_word[1]`=0, every `clk` edge is active.
- R5: `pt_arst`=1 clears the stored bit without waiting for a clock edge. It overrides preload, preset and data.
- R6: `sync_preset`=1 at an active edge sets the stored bit to 1, over D or T data. At an edge that is not active it has no effect.
- R7: `preload_en`=1 loads `preload_val` at any `clk` edge, whether or not the edge is active. Preload overrides preset and data.
- R8: With `cfg_word[2]`=0, the register term and the combinational term are both `sum_a|sum_b`. With `cfg_word[2]`=1, the register term is `sum_a` and the combinational term is `sum_b`.
- R9: With `cfg_word[3]`=0, `pin_o` equals the stored bit. With `cfg_word[3]`=1, `pin_o` equals the combinational term, with no clock delay.
- R10: `pin_oe` follows `pt_oe` combinationally. A value of 0 means the pin is high-impedance.
- R11: `fb_o` always carries the stored bit, whatever the pin mode or enable.
- R12: A change of `cfg_word` while `rst_n` is high has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Direct clock pin, shared by all cells |
| rst_n | input | 1 | Power-up reset, active low; captures configuration |
| cfg_word | input | 4 | Static configuration: [0] T mode, [1] product-term clock, [2] split terms, [3] combinational pin |
| sum_a | input | 1 | First sum term from the array |
| sum_b | input | 1 | Second sum term from the array |
| pt_clk | input | 1 | Product-term clock for this cell |
| pt_arst | input | 1 | Product-term asynchronous clear |
| pt_oe | input | 1 | Product-term output enable |
| sync_preset | input | 1 | Shared synchronous preset term |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Value loaded by preload |
| pin_o | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Pin driver enable; 0 means high-impedance |
| fb_o | output | 1 | Stored bit fed back to the array |

## Verification
Register results are due one `clk` edge after their inputs are set. The bench changes inputs 1 ns after a rising edge and reads `fb_o` 1 ns after the following edge. This covers data, toggle, preset, preload and product-term-clock updates. Combinational results need no clock edge and are read 1 ns after the inputs change: `pin_o` in combinational mode, and `pin_oe`. The asynchronous clear is checked 1 ns after `pt_arst` rises, well before the next edge, which proves it does not wait for the clock. Product-term clock cases count edges on which `pt_clk` stays high, to show that only the first of them updates the bit.

// File: rtl/pldmc_pkg.sv
`timescale 1ns/1ps
package pldmc_pkg;

    localparam int CFG_W = 4;

    // bit 3: combinational pin, bit 2: split terms, bit 1: product-term clock, bit 0: T mode
    typedef struct packed {
        logic comb_pin;
        logic split_terms;
        logic ptclk_sel;
        logic toggle_mode;
    } cell_cfg_t;

    typedef enum logic {
        BIT_CLR = 1'b0,
        BIT_SET = 1'b1
    } bit_state_t;

    typedef enum logic [2:0] {
        EV_HOLD    = 3'd0,
        EV_LOAD_D  = 3'd1,
        EV_TOGGLE  = 3'd2,
        EV_PRESET  = 3'd3,
        EV_PRELOAD = 3'd4
    } cell_event_t;

endpackage

// File: rtl/pldmc_cfg_hold.sv
`timescale 1ns/1ps
module pldmc_cfg_hold
    import pldmc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_W-1:0]     cfg_in,
    output cell_cfg_t            cfg_q
);

    // Configuration is sampled only during reset; frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= cell_cfg_t'(cfg_in);
        end
    end

endmodule

// File: rtl/pldmc_clk_sel.sv
`timescale 1ns/1ps
module pldmc_clk_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic ptclk_sel,
    input  logic pt_clk,
    output logic fire
);

    logic pt_clk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_clk_q <= 1'b0;
        end else begin
            pt_clk_q <= pt_clk;
        end
    end

    // Active edge: every clk edge on the pin clock, or a rising product-term clock.
    always_comb begin
        if (ptclk_sel) begin
            fire = pt_clk & ~pt_clk_q;
        end else begin
            fire = 1'b1;
        end
    end

endmodule

// File: rtl/pldmc_term_route.sv
`timescale 1ns/1ps
module pldmc_term_route (
    input  logic split_terms,
    input  logic sum_a,
    input  logic sum_b,
    output logic reg_term,
    output logic comb_term
);

    always_comb begin
        if (split_terms) begin
            reg_term  = sum_a;
            comb_term = sum_b;
        end else begin
            reg_term  = sum_a | sum_b;
            comb_term = sum_a | sum_b;
        end
    end

endmodule

// File: rtl/pldmc_state_core.sv
`timescale 1ns/1ps
module pldmc_state_core
    import pldmc_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic toggle_mode,
    input  logic fire,
    input  logic preset,
    input  logic preload_en,
    input  logic preload_val,
    input  logic reg_term,
    output logic q
);

    bit_state_t  state;
    bit_state_t  state_nx;
    cell_event_t ev;

    // State register: asynchronous clear wins over every clocked event.
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            state <= BIT_CLR;
        end else begin
            state <= state_nx;
        end
    end

    // Event selection in priority order, then next state.
    always_comb begin
        if (preload_en) begin
            ev = EV_PRELOAD;
        end else if (!fire) begin
            ev = EV_HOLD;
        end else if (preset) begin
            ev = EV_PRESET;
        end else if (toggle_mode) begin
            ev = reg_term ? EV_TOGGLE : EV_HOLD;
        end else begin
            ev = EV_LOAD_D;
        end

        unique case (ev)
            EV_PRELOAD: state_nx = preload_val ? BIT_SET : BIT_CLR;
            EV_PRESET:  state_nx = BIT_SET;
            EV_TOGGLE:  state_nx = (state == BIT_SET) ? BIT_CLR : BIT_SET;
            EV_LOAD_D:  state_nx = reg_term ? BIT_SET : BIT_CLR;
            default:    state_nx = state;
        endcase
    end

    // Output process
    always_comb begin
        q = (state == BIT_SET);
    end

endmodule

// File: rtl/pldmc_cell.sv
`timescale 1ns/1ps
module pldmc_cell
    import pldmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             sum_a,
    input  logic             sum_b,
    input  logic             pt_clk,
    input  logic             pt_arst,
    input  logic             pt_oe,
    input  logic             sync_preset,
    input  logic             preload_en,
    input  logic             preload_val,
    output logic             pin_o,
    output logic             pin_oe,
    output logic             fb_o
);

    cell_cfg_t cfg_q;
    logic      fire;
    logic      reg_term;
    logic      comb_term;
    logic      q;
    logic      clr;

    assign clr = pt_arst | ~rst_n;

    pldmc_cfg_hold u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_word),
        .cfg_q  (cfg_q)
    );

    pldmc_clk_sel u_clk_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptclk_sel (cfg_q.ptclk_sel),
        .pt_clk    (pt_clk),
        .fire      (fire)
    );

    pldmc_term_route u_route (
        .split_terms (cfg_q.split_terms),
        .sum_a       (sum_a),
        .sum_b       (sum_b),
        .reg_term    (reg_term),
        .comb_term   (comb_term)
    );

    pldmc_state_core u_core (
        .clk         (clk),
        .clr         (clr),
        .toggle_mode (cfg_q.toggle_mode),
        .fire        (fire),
        .preset      (sync_preset),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .reg_term    (reg_term),
        .q           (q)
    );

    always_comb begin
        pin_o  = cfg_q.comb_pin ? comb_term : q;
        pin_oe = pt_oe;
        fb_o   = q;
    end

endmodule

// File: rtl/pldmc_cell_chk.sv
`timescale 1ns/1ps
module pldmc_cell_chk
    import pldmc_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      pt_arst,
    input logic      preload_en,
    input logic      preload_val,
    input logic      sync_preset,
    input logic      fire,
    input cell_cfg_t cfg,
    input logic      reg_term,
    input logic      pin_o,
    input logic      fb_o
);

    // R5
    arst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pt_arst |-> !fb_o);

    // R7
    preload_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !pt_arst) |=> (pt_arst || (fb_o == $past(preload_val))));

    // R6
    preset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sync_preset && !preload_en && !pt_arst) |=> (pt_arst || fb_o));

    // R2
    d_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cfg.toggle_mode && !sync_preset && !preload_en && !pt_arst)
        |=> (pt_arst || (fb_o == $past(reg_term))));

    // R4
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !preload_en && !pt_arst) |=> (pt_arst || $stable(fb_o)));

    // R9
    reg_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.comb_pin |-> (pin_o == fb_o));

endmodule

bind pldmc_cell pldmc_cell_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pt_arst     (pt_arst),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .sync_preset (sync_preset),
    .fire        (fire),
    .cfg         (cfg_q),
    .reg_term    (reg_term),
    .pin_o       (pin_o),
    .fb_o        (fb_o)
);

// File: tb/test_pldmc_cell.sv
`timescale 1ns/1ps
module test_pldmc_cell;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_word = 4'b0000;
    logic       sum_a = 1'b0;
    logic       sum_b = 1'b0;
    logic       pt_clk = 1'b0;
    logic       pt_arst = 1'b0;
    logic       pt_oe = 1'b0;
    logic       sync_preset = 1'b0;
    logic       preload_en = 1'b0;
    logic       preload_val = 1'b0;
    logic       pin_o;
    logic       pin_oe;
    logic       fb_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pldmc_cell i_pldmc_cell (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_word    (cfg_word),
        .sum_a       (sum_a),
        .sum_b       (sum_b),
        .pt_clk      (pt_clk),
        .pt_arst     (pt_arst),
        .pt_oe       (pt_oe),
        .sync_preset (sync_preset),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .pin_o       (pin_o),
        .pin_oe      (pin_oe),
        .fb_o        (fb_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [3:0] c);
        rst_n = 1'b0; cfg_word = c;
        sum_a = 0; sum_b = 0; pt_clk = 0; pt_arst = 0; pt_oe = 0;
        sync_preset = 0; preload_en = 0; preload_val = 0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(4'b0000);
        chk("R1 reset state", fb_o, 1'b0);
        chk("R9 registered pin after reset", pin_o, 1'b0);
        chk("R10 enable off after reset", pin_oe, 1'b0);
    endtask

    task automatic t_dmode();
        do_reset(4'b0000);
        sum_a = 1; tick();
        chk("R2 D load 1", fb_o, 1'b1);
        sum_a = 0; sum_b = 1; tick();
        chk("R8 combined via sum_b", fb_o, 1'b1);
        chk("R9 pin tracks register", pin_o, 1'b1);
        sum_b = 0; tick();
        chk("R2 D load 0", fb_o, 1'b0);
    endtask

    task automatic t_tmode();
        do_reset(4'b0001);
        sum_a = 1; tick();
        chk("R3 toggle to 1", fb_o, 1'b1);
        tick();
        chk("R3 toggle to 0", fb_o, 1'b0);
        tick();
        chk("R3 toggle to 1 again", fb_o, 1'b1);
        sum_a = 0; tick(); tick();
        chk("R3 hold on term 0", fb_o, 1'b1);
    endtask

    task automatic t_ptclk();
        do_reset(4'b0010);
        sum_a = 1; tick(); tick();
        chk("R4 no product-term edge, no update", fb_o, 1'b0);
        pt_clk = 1; tick();
        chk("R4 update on product-term rise", fb_o, 1'b1);
        sum_a = 0; tick();
        chk("R4 held-high clock gives no second update", fb_o, 1'b1);
        pt_clk = 0; tick();
        chk("R4 falling clock no update", fb_o, 1'b1);
        pt_clk = 1; tick();
        chk("R4 second rise loads 0", fb_o, 1'b0);
        pt_clk = 0;
    endtask

    task automatic t_arst();
        do_reset(4'b0000);
        sum_a = 1; tick();
        chk("R5 precondition set", fb_o, 1'b1);
        pt_arst = 1; #1;
        chk("R5 immediate clear", fb_o, 1'b0);
        preload_en = 1; preload_val = 1; sync_preset = 1;
        tick();
        chk("R5 clear beats preload and preset", fb_o, 1'b0);
        pt_arst = 0; preload_en = 0; preload_val = 0; sync_preset = 0;
        tick();
        chk("R5 resumes after clear", fb_o, 1'b1);
        sum_a = 0;
    endtask

    task automatic t_preset();
        do_reset(4'b0000);
        sync_preset = 1; tick();
        chk("R6 preset over D 0", fb_o, 1'b1);
        sync_preset = 0; tick();
        chk("R6 preset released", fb_o, 1'b0);
        do_reset(4'b0011);
        sync_preset = 1; tick();
        chk("R6 no active edge, no preset", fb_o, 1'b0);
        pt_clk = 1; tick();
        chk("R6 preset at product-term edge", fb_o, 1'b1);
        sync_preset = 0; pt_clk = 0;
    endtask

    task automatic t_preload();
        do_reset(4'b0010);
        preload_en = 1; preload_val = 1; tick();
        chk("R7 preload without active edge", fb_o, 1'b1);
        preload_val = 0; sync_preset = 1; pt_clk = 1; tick();
        chk("R7 preload beats preset", fb_o, 1'b0);
        preload_en = 0; sync_preset = 0; pt_clk = 0; tick();
        chk("R7 no change after preload ends", fb_o, 1'b0);
    endtask

    task automatic t_route();
        do_reset(4'b1100);
        sum_a = 0; sum_b = 1; #1;
        chk("R9 comb pin shows sum_b", pin_o, 1'b1);
        tick();
        chk("R8 split: register takes sum_a", fb_o, 1'b0);
        sum_a = 1; sum_b = 0; #1;
        chk("R9 comb pin follows sum_b low", pin_o, 1'b0);
        tick();
        chk("R11 feedback carries buried register", fb_o, 1'b1);
        chk("R11 pin independent of register", pin_o, 1'b0);
        do_reset(4'b1000);
        sum_a = 1; sum_b = 0; #1;
        chk("R8 combined comb via sum_a", pin_o, 1'b1);
        sum_a = 0; sum_b = 1; #1;
        chk("R8 combined comb via sum_b", pin_o, 1'b1);
        sum_b = 0; #1;
        chk("R8 combined comb both low", pin_o, 1'b0);
    endtask

    task automatic t_oe();
        do_reset(4'b0000);
        sum_a = 1; tick();
        pt_oe = 1; #1;
        chk("R10 enable on", pin_oe, 1'b1);
        pt_oe = 0; #1;
        chk("R10 enable off", pin_oe, 1'b0);
        chk("R11 feedback while pin disabled", fb_o, 1'b1);
        sum_a = 0;
    endtask

    task automatic t_cfg_static();
        do_reset(4'b0000);
        cfg_word = 4'b0001;
        sum_a = 1; tick(); tick();
        chk("R12 config change ignored, still D", fb_o, 1'b1);
        do_reset(4'b0001);
        sum_a = 1; tick(); tick();
        chk("R12 new config after reset, T mode", fb_o, 1'b0);
        sum_a = 0;
    endtask

    initial begin
        t_reset();
        t_dmode();
        t_tmode();
        t_ptclk();
        t_arst();
        t_preset();
        t_preload();
        t_route();
        t_oe();
        t_cfg_static();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule